// File: doc/BRIEF.md
# Two-Slot Container Ping-Pong Buffer

This block sits inside one channel of a packet DMA path and holds two 4096-byte containers. A producer fills one container while a consumer drains the other. Ownership passes between the two sides one whole container at a time, not word by word.

Each slot carries one status bit: 1 means full and 0 means empty. The producer works only on its current slot, and only while that slot is empty. When it signals done, the slot is marked full and the producer moves to the other slot. The consumer works the same way in reverse: it reads only a full slot, and when it signals done, the slot is marked empty and the consumer moves on.

Data moves through 32-bit word ports. A 10-bit word offset selects a word inside the side's current container. A stored packet of 54 to 1514 bytes therefore takes 14 to 379 words of one container.

Top module: `cont_ring2`

## Requirements
- R1: After synchronous reset both slots are empty, `prod_slot` and `cons_slot` are 0, `prod_avail` is 1, `cons_avail` is 0 and `rd_data` is 0.
- R2: `prod_avail` is 1 exactly when the producer's current slot is empty. It is 0 when both slots are full. `cons_avail` is 1 exactly when the consumer's current slot is full. It is 0 when both slots are empty.
- R3: `prod_done` in a cycle with `prod_avail` high marks that slot full and toggles `prod_slot` at the next edge.
- R4: `cons_done` in a cycle with `cons_avail` high marks that slot empty and toggles `cons_slot` at the next edge.
- R5: `prod_done` while `prod_avail` is low, and `cons_done` while `cons_avail` is low, change neither pointer nor any status.
- R6: `wr_en` while `prod_avail` is low writes nothing. Data already stored in either slot is unchanged.
- R7: `rd_en` while `cons_avail` is high returns, one cycle later on `rd_data`, the word last written at `rd_off` of the consumer's slot. Reading changes no stored data.
- R8: `rd_en` while `cons_avail` is low leaves `rd_data` holding its previous value.
- R9: When the producer fills one slot and the consumer releases the other in the same cycle, both status changes and both pointer toggles take effect.
- R10: The word offset spans the whole container. Offsets 0 and 1023 address distinct words, and a 1514-byte packet (379 words) fits in one slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prod_avail | output | 1 | Producer's current slot is empty and writable |
| prod_slot | output | 1 | Producer's current slot index |
| wr_en | input | 1 | Write one word into the producer's slot |
| wr_off | input | 10 | Word offset for the write |
| wr_data | input | 32 | Write data |
| prod_done | input | 1 | Producer hands the filled slot over |
| cons_avail | output | 1 | Consumer's current slot is full and readable |
| cons_slot | output | 1 | Consumer's current slot index |
| rd_en | input | 1 | Read one word from the consumer's slot |
| rd_off | input | 10 | Word offset for the read |
| rd_data | output | 32 | Read data, valid one cycle after an accepted read |
| cons_done | input | 1 | Consumer releases the drained slot |

## Verification
The embedded assertions check on every cycle how the status bits and pointers react to done requests. They cover the toggle on an accepted hand-over, the hold on a refused one, the both-full and both-empty gating of the available flags, and the net status count when both hand-overs coincide. They also check that `rd_data` holds when a read is refused. Only the bench's scenarios can show that words land in the right slot and offset, that a refused write leaves the stored data untouched, and that data written by the producer returns intact after the container changes hands. The bench does this by comparing against a model of both containers.

// File: rtl/cr2_pkg.sv
package cr2_pkg;

    localparam int DEF_WORD_W     = 32;
    localparam int DEF_CONT_BYTES = 4096;
    localparam int SLOT_COUNT     = 2;

    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_FULL  = 1'b1
    } slot_state_e;

    function automatic logic next_slot(input logic cur);
        return ~cur;
    endfunction

endpackage

// File: rtl/cr2_slot_ctrl.sv
module cr2_slot_ctrl
    import cr2_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic prod_done,
    input  logic cons_done,
    output logic prod_slot,
    output logic cons_slot,
    output logic prod_avail,
    output logic cons_avail
);

    slot_state_e state_q [SLOT_COUNT];
    logic [SLOT_COUNT-1:0] full_vec;
    logic prod_ptr_q, cons_ptr_q;
    logic prod_fire, cons_fire;

    assign prod_avail = (state_q[prod_ptr_q] == SLOT_EMPTY);
    assign cons_avail = (state_q[cons_ptr_q] == SLOT_FULL);
    assign prod_fire  = prod_done && prod_avail;
    assign cons_fire  = cons_done && cons_avail;
    assign prod_slot  = prod_ptr_q;
    assign cons_slot  = cons_ptr_q;

    for (genvar i = 0; i < SLOT_COUNT; i++) begin : g_slot
        assign full_vec[i] = (state_q[i] == SLOT_FULL);
        always_ff @(posedge clk) begin
            if (rst) begin
                state_q[i] <= SLOT_EMPTY;
            end else if (prod_fire && (prod_ptr_q == 1'(i))) begin
                state_q[i] <= SLOT_FULL;
            end else if (cons_fire && (cons_ptr_q == 1'(i))) begin
                state_q[i] <= SLOT_EMPTY;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prod_ptr_q <= 1'b0;
            cons_ptr_q <= 1'b0;
        end else begin
            if (prod_fire) prod_ptr_q <= next_slot(prod_ptr_q);
            if (cons_fire) cons_ptr_q <= next_slot(cons_ptr_q);
        end
    end

    a_r3_prod_toggle: assert property (@(posedge clk) disable iff (rst)
        prod_done && prod_avail |=> prod_slot != $past(prod_slot));
    a_r4_cons_toggle: assert property (@(posedge clk) disable iff (rst)
        cons_done && cons_avail |=> cons_slot != $past(cons_slot));
    a_r5_prod_refused: assert property (@(posedge clk) disable iff (rst)
        prod_done && !prod_avail && !cons_done |=> $stable(prod_slot) && $stable(full_vec));
    a_r5_cons_refused: assert property (@(posedge clk) disable iff (rst)
        cons_done && !cons_avail && !prod_done |=> $stable(cons_slot) && $stable(full_vec));
    a_r2_both_full: assert property (@(posedge clk) disable iff (rst)
        $countones(full_vec) == SLOT_COUNT |-> !prod_avail);
    a_r2_both_empty: assert property (@(posedge clk) disable iff (rst)
        $countones(full_vec) == 0 |-> !cons_avail);
    a_r9_dual_handover: assert property (@(posedge clk) disable iff (rst)
        prod_done && prod_avail && cons_done && cons_avail
        |=> $countones(full_vec) == $past($countones(full_vec)) && cons_slot != $past(cons_slot));

endmodule

// File: rtl/cr2_store.sv
module cr2_store #(
    parameter int WORD_W = 32,
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];
    logic [WORD_W-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_q <= '0;
        else if (rd_en) rd_q <= mem[rd_addr];
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/cont_ring2.sv
module cont_ring2
    import cr2_pkg::*;
#(
    parameter int WORD_W     = DEF_WORD_W,
    parameter int CONT_BYTES = DEF_CONT_BYTES
) (
    input  logic                                       clk,
    input  logic                                       rst,
    output logic                                       prod_avail,
    output logic                                       prod_slot,
    input  logic                                       wr_en,
    input  logic [$clog2(CONT_BYTES/(WORD_W/8))-1:0]   wr_off,
    input  logic [WORD_W-1:0]                          wr_data,
    input  logic                                       prod_done,
    output logic                                       cons_avail,
    output logic                                       cons_slot,
    input  logic                                       rd_en,
    input  logic [$clog2(CONT_BYTES/(WORD_W/8))-1:0]   rd_off,
    output logic [WORD_W-1:0]                          rd_data,
    input  logic                                       cons_done
);

    localparam int WORDS_PER_CONT = CONT_BYTES / (WORD_W / 8);
    localparam int OFF_W          = $clog2(WORDS_PER_CONT);
    localparam int ADDR_W         = OFF_W + $clog2(SLOT_COUNT);

    logic wr_ok, rd_ok;

    cr2_slot_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .prod_done  (prod_done),
        .cons_done  (cons_done),
        .prod_slot  (prod_slot),
        .cons_slot  (cons_slot),
        .prod_avail (prod_avail),
        .cons_avail (cons_avail)
    );

    assign wr_ok = wr_en && prod_avail;
    assign rd_ok = rd_en && cons_avail;

    cr2_store #(
        .WORD_W (WORD_W),
        .ADDR_W (ADDR_W)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_ok),
        .wr_addr ({prod_slot, wr_off}),
        .wr_data (wr_data),
        .rd_en   (rd_ok),
        .rd_addr ({cons_slot, rd_off}),
        .rd_data (rd_data)
    );

    a_r8_read_hold: assert property (@(posedge clk) disable iff (rst)
        !(rd_en && cons_avail) |=> $stable(rd_data));
    a_r2_one_side_on_shared_slot: assert property (@(posedge clk) disable iff (rst)
        prod_slot == cons_slot |-> prod_avail != cons_avail);

endmodule

// File: tb/test_cont_ring2.sv
module test_cont_ring2;

    localparam int OFF_W = 10;

    logic clk = 1'b0;
    logic rst;
    logic prod_avail, prod_slot, cons_avail, cons_slot;
    logic wr_en, prod_done, rd_en, cons_done;
    logic [OFF_W-1:0] wr_off, rd_off;
    logic [31:0] wr_data, rd_data;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    logic [31:0] m_mem [2][1024];
    bit          m_wr  [2][1024];
    bit          m_full [2];
    bit          m_pp, m_cp;
    logic [31:0] m_rd;
    bit          m_rd_known;

    always #2.5 clk = ~clk;

    cont_ring2 i_cont_ring2 (
        .clk(clk), .rst(rst),
        .prod_avail(prod_avail), .prod_slot(prod_slot),
        .wr_en(wr_en), .wr_off(wr_off), .wr_data(wr_data), .prod_done(prod_done),
        .cons_avail(cons_avail), .cons_slot(cons_slot),
        .rd_en(rd_en), .rd_off(rd_off), .rd_data(rd_data), .cons_done(cons_done)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit exp_pavail();
        return !m_full[m_pp];
    endfunction

    function automatic bit exp_cavail();
        return m_full[m_cp];
    endfunction

    task automatic check_state(input string req);
        chk(prod_avail === exp_pavail(), {req, " prod_avail"}, 32'(prod_avail), 32'(exp_pavail()));
        chk(cons_avail === exp_cavail(), {req, " cons_avail"}, 32'(cons_avail), 32'(exp_cavail()));
        chk(prod_slot === m_pp, {req, " prod_slot"}, 32'(prod_slot), 32'(m_pp));
        chk(cons_slot === m_cp, {req, " cons_slot"}, 32'(cons_slot), 32'(m_cp));
        if (m_rd_known)
            chk(rd_data === m_rd, {req, " rd_data"}, rd_data, m_rd);
    endtask

    task automatic cyc(input bit we, input logic [9:0] wo, input logic [31:0] wd, input bit pd,
                       input bit re, input logic [9:0] ro, input bit cd);
        bit pa, ca;
        @(negedge clk);
        wr_en = we; wr_off = wo; wr_data = wd; prod_done = pd;
        rd_en = re; rd_off = ro; cons_done = cd;
        pa = exp_pavail();
        ca = exp_cavail();
        @(posedge clk);
        if (re && ca) begin
            m_rd_known = m_wr[m_cp][ro];
            m_rd = m_mem[m_cp][ro];
        end
        if (we && pa) begin
            m_mem[m_pp][wo] = wd;
            m_wr[m_pp][wo] = 1'b1;
        end
        if (pd && pa) begin m_full[m_pp] = 1'b1; m_pp = ~m_pp; end
        if (cd && ca) begin m_full[m_cp] = 1'b0; m_cp = ~m_cp; end
        #1;
    endtask

    task automatic idle();
        cyc(0, '0, '0, 0, 0, '0, 0);
    endtask

    initial begin : watchdog
        #900000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%h expected=%h", 32'd0, 32'd1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] held;
        void'($urandom(32'h5eed_c0de));
        for (int s = 0; s < 2; s++)
            for (int o = 0; o < 1024; o++) begin m_wr[s][o] = 0; m_mem[s][o] = '0; end
        m_full[0] = 0; m_full[1] = 0; m_pp = 0; m_cp = 0; m_rd = '0; m_rd_known = 1;
        rst = 1;
        wr_en = 0; wr_off = '0; wr_data = '0; prod_done = 0;
        rd_en = 0; rd_off = '0; cons_done = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #1;
        // R1 reset state
        check_state("R1");
        chk(prod_avail === 1'b1 && cons_avail === 1'b0, "R1 avail", {prod_avail, cons_avail}, 2'b10);

        // R10: 1514-byte packet (379 words) plus both end offsets in slot 0
        for (int i = 0; i < 379; i++) cyc(1, 10'(i), 32'hA000_0000 + i, 0, 0, '0, 0);
        cyc(1, 10'd1023, 32'hFFFF_1023, 0, 0, '0, 0);
        cyc(1, 10'd0, 32'h0000_0C0C, 1, 0, '0, 0);
        // R3 slot 0 handed over
        check_state("R3");
        chk(prod_slot === 1'b1 && cons_avail === 1'b1, "R3 handover", {prod_slot, cons_avail}, 2'b11);

        // fill slot 1, then both full
        cyc(1, 10'd5, 32'hB1B1_0005, 1, 0, '0, 0);
        check_state("R2");
        chk(prod_avail === 1'b0, "R2 both full", 32'(prod_avail), 32'd0);

        // R6: write while full ignored; R5: done while full ignored
        cyc(1, 10'd0, 32'hDEAD_BEEF, 1, 0, '0, 0);
        check_state("R5");
        chk(prod_slot === 1'b0, "R5 prod_slot hold", 32'(prod_slot), 32'd0);

        // R7 / R10 read back slot 0 words at offsets 0, 1023, 378
        cyc(0, '0, '0, 0, 1, 10'd0, 0);
        idle();
        chk(rd_data === 32'h0000_0C0C, "R6 R10 offset0 untouched", rd_data, 32'h0000_0C0C);
        cyc(0, '0, '0, 0, 1, 10'd1023, 0);
        chk(rd_data === 32'hFFFF_1023, "R10 offset1023", rd_data, 32'hFFFF_1023);
        cyc(0, '0, '0, 0, 1, 10'd378, 0);
        chk(rd_data === 32'hA000_017A, "R7 last packet word", rd_data, 32'hA000_017A);

        // release slot 0, read slot 1
        cyc(0, '0, '0, 0, 1, 10'd1, 1);
        check_state("R4");
        chk(cons_slot === 1'b1 && prod_avail === 1'b1, "R4 release", {cons_slot, prod_avail}, 2'b11);

        // R9: producer fills slot 0 while consumer releases slot 1
        cyc(1, 10'd7, 32'h0707_0707, 0, 1, 10'd5, 0);
        chk(rd_data === 32'hB1B1_0005, "R7 slot1 word", rd_data, 32'hB1B1_0005);
        cyc(0, '0, '0, 1, 0, '0, 1);
        check_state("R9");
        chk(prod_slot === 1'b1 && cons_slot === 1'b0 && cons_avail === 1'b1 && prod_avail === 1'b1,
            "R9 dual", {prod_slot, cons_slot, cons_avail, prod_avail}, 4'b1011);

        // drain slot 0; then R8: read while empty holds rd_data
        cyc(0, '0, '0, 0, 1, 10'd7, 1);
        chk(rd_data === 32'h0707_0707, "R7 slot0 refill", rd_data, 32'h0707_0707);
        held = rd_data;
        cyc(0, '0, '0, 0, 1, 10'd7, 0);
        chk(rd_data === held && cons_avail === 1'b0, "R8 hold", rd_data, held);
        // R5 consumer done while empty
        cyc(0, '0, '0, 0, 0, '0, 1);
        check_state("R5");

        // random phase
        for (int n = 0; n < 4000; n++) begin
            cyc(($urandom % 2) == 0, 10'($urandom), $urandom, ($urandom % 16) == 0,
                ($urandom % 2) == 0, 10'($urandom % 64), ($urandom % 16) == 0);
            check_state("R7");
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule